// File: doc/BRIEF.md
# Byte-Count Transfer Sequencer

This block runs the master side of a serial-bus transfer one byte at a time. Software sets up a control word and a byte count. The block then asks a byte-level bus engine to perform four kinds of request: send the slave address, send a byte, receive a byte, or end the transfer. It waits for each request to finish before it issues the next one. The block moves bytes between the engine and a small shared byte buffer. Software fills that buffer when transmitting and empties it when receiving.

Each byte moved lowers a working count. When the count runs out, the block does one of two things. If a stop was requested, it ends the transfer, then sets an access-ready event and drops master mode. If no stop was requested, it sets access-ready and drops master mode but leaves the bus held. In repeat mode the count is not used: the block keeps moving bytes until software asks for a stop. A byte that is not acknowledged halts the transfer and sets a no-acknowledge event. The engine handles bit timing on the wires; this block does not.

Top module: `byte_xfer_seq`

## Requirements
- R1: After reset, the control word, the working count and the buffer level are zero, no engine request is pending, and all four status outputs are low.
- R2: A control write stores only the bits under mask 0xCF87. Bit 0 is start, bit 1 is stop, bit 2 is repeat, bit 9 is transmit, bit 10 is master and bit 15 is enable. No transfer begins unless start, master and enable are all set.
- R3: A start issues engine op 0 with data {slave_addr, dir}, where dir is 1 for receive and 0 for transmit. When that op completes with an acknowledge, the start bit clears and the working count is loaded from the programmed count.
- R4: If the address is not acknowledged, no_ack goes high, op 3 (end) is issued, and the stop and master bits clear.
- R5: In counted transmit, each buffered byte is sent with op 1, in the order it was pushed, and each one lowers the count by one. The block waits while the buffer is empty. tx_ready is high while the transfer runs and the count is nonzero.
- R6: In counted receive, op 2 is issued while the count is nonzero and the buffer (depth 4) is not full. Received bytes are read out in the order they arrived, and each one lowers the count. rx_ready is high when in receive mode and the buffer is not empty.
- R7: If the count is zero and no stop was requested, access_ready goes high and master clears. No end op is issued, and the count reads back as zero.
- R8: If the count is zero and a stop was requested, op 3 is issued, stop and master clear, and access_ready goes high. Every completed end op reloads the working count from the programmed count.
- R9: A sent byte that is not acknowledged sets no_ack. No further byte is sent, op 3 is issued, and stop and master clear.
- R10: In repeat mode the count does not change. Transmit sends every buffered byte. Receive fills the buffer to 4 bytes and then waits. A stop request issues op 3 at once without raising access_ready.
- R11: At most one engine op is outstanding. eng_valid, eng_op and eng_data stay steady until eng_done.
- R12: access_ready and no_ack stay high until their own clear input is pulsed. Each clear input affects only its own flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write data |
| ctl_q | output | 16 | Current control word |
| cnt_we | input | 1 | Programmed count write strobe |
| cnt_wdata | input | CNT_W | Programmed count |
| cnt_q | output | CNT_W | Working (remaining) count |
| slave_addr | input | 7 | Slave address |
| buf_push | input | 1 | Push a transmit byte (transmit mode) |
| buf_wdata | input | 8 | Transmit byte |
| buf_pop | input | 1 | Pop a received byte (receive mode) |
| buf_rdata | output | 8 | Byte at the buffer head |
| buf_level | output | $clog2(DEPTH+1) | Bytes held in the buffer |
| eng_valid | output | 1 | Engine request pending |
| eng_op | output | 2 | 0 address, 1 send, 2 receive, 3 end |
| eng_data | output | 8 | Address-plus-direction or byte to send |
| eng_done | input | 1 | One-cycle completion strobe |
| eng_ack | input | 1 | Acknowledge for address or sent byte |
| eng_rdata | input | 8 | Received byte, valid with eng_done |
| access_ready | output | 1 | Sticky count-expired event |
| no_ack | output | 1 | Sticky not-acknowledged event |
| tx_ready | output | 1 | Transmit can accept data |
| rx_ready | output | 1 | Received data available |
| ardy_clr | input | 1 | Clear access_ready |
| nack_clr | input | 1 | Clear no_ack |

## Verification
Assertions check the following on every cycle: a pending request stays steady, a send op only appears in transmit mode, a refused send is followed by an end op with no_ack set, access_ready only rises once master is clear, and the count holds in repeat mode. The bench scenarios cover the rest. These include the exact op sequence and byte order for each count and stop setting, the count reload, the stall on a full receive buffer, address refusal, and which bits of the control word survive each ending.

// File: rtl/byte_xfer_seq.sv
module byte_xfer_seq #(
  parameter int CNT_W = 16,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ctl_we,
  input  logic [15:0]                ctl_wdata,
  output logic [15:0]                ctl_q,
  input  logic                       cnt_we,
  input  logic [CNT_W-1:0]           cnt_wdata,
  output logic [CNT_W-1:0]           cnt_q,
  input  logic [6:0]                 slave_addr,
  input  logic                       buf_push,
  input  logic [7:0]                 buf_wdata,
  input  logic                       buf_pop,
  output logic [7:0]                 buf_rdata,
  output logic [$clog2(DEPTH+1)-1:0] buf_level,
  output logic                       eng_valid,
  output logic [1:0]                 eng_op,
  output logic [7:0]                 eng_data,
  input  logic                       eng_done,
  input  logic                       eng_ack,
  input  logic [7:0]                 eng_rdata,
  output logic                       access_ready,
  output logic                       no_ack,
  output logic                       tx_ready,
  output logic                       rx_ready,
  input  logic                       ardy_clr,
  input  logic                       nack_clr
);
  // DEPTH must be a power of two so the pointers wrap naturally
  localparam int LW = $clog2(DEPTH + 1);
  localparam int PW = $clog2(DEPTH);
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);
  localparam logic [15:0] CTL_MASK = 16'hCF87;
  localparam logic [1:0] OP_START = 2'd0, OP_SEND = 2'd1, OP_RECV = 2'd2, OP_END = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_RUN, S_XFER, S_FIN} st_t;
  st_t state;

  logic [CNT_W-1:0] cnt_prog, cnt_cur;
  logic [7:0]       mem [DEPTH];
  logic [PW-1:0]    wp, rp;
  logic [LW-1:0]    lvl;
  logic [15:0]      ctl_nx;

  wire trx = ctl_q[9];
  wire rpt = ctl_q[2];
  wire stp = ctl_q[1];
  wire full  = (lvl == FULL_LVL);
  wire empty = (lvl == '0);
  wire cnt_zero = (cnt_cur == '0);

  wire addr_done = (state == S_ADDR) && eng_done;
  wire addr_nak  = addr_done && !eng_ack;
  wire xfer_done = (state == S_XFER) && eng_done;
  wire eng_push  = xfer_done && (eng_op == OP_RECV);
  wire eng_pop   = xfer_done && (eng_op == OP_SEND);
  wire data_nak  = eng_pop && !eng_ack;
  wire fin_done  = (state == S_FIN) && eng_done;

  wire do_push = trx ? (buf_push && !full) : eng_push;
  wire do_pop  = trx ? eng_pop : (buf_pop && !empty);
  wire [7:0] push_byte = trx ? buf_wdata : eng_rdata;

  logic issue_send, issue_recv, go_fin, expire;
  always_comb begin
    issue_send = 1'b0;
    issue_recv = 1'b0;
    go_fin     = 1'b0;
    expire     = 1'b0;
    if (state == S_RUN) begin
      if (rpt) begin
        if (stp)      go_fin = 1'b1;
        else if (trx) issue_send = !empty;
        else          issue_recv = !full;
      end else if (cnt_zero) begin
        expire = 1'b1;
        go_fin = stp;
      end else if (trx) issue_send = !empty;
      else              issue_recv = !full;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      eng_op   <= OP_START;
      eng_data <= '0;
    end else begin
      case (state)
        S_IDLE: if (ctl_q[15] && ctl_q[10] && ctl_q[0]) begin
          state    <= S_ADDR;
          eng_op   <= OP_START;
          eng_data <= {slave_addr, !trx};
        end
        S_ADDR: if (eng_done) begin
          if (!eng_ack) begin
            state  <= S_FIN;
            eng_op <= OP_END;
          end else state <= S_RUN;
        end
        S_RUN: begin
          if (issue_send) begin
            state    <= S_XFER;
            eng_op   <= OP_SEND;
            eng_data <= mem[rp];
          end else if (issue_recv) begin
            state    <= S_XFER;
            eng_op   <= OP_RECV;
            eng_data <= '0;
          end else if (go_fin) begin
            state  <= S_FIN;
            eng_op <= OP_END;
          end else if (expire) state <= S_IDLE;
        end
        S_XFER: if (eng_done) begin
          if (data_nak) begin
            state  <= S_FIN;
            eng_op <= OP_END;
          end else state <= S_RUN;
        end
        S_FIN:  if (eng_done) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign eng_valid = (state == S_ADDR) || (state == S_XFER) || (state == S_FIN);

  always_comb begin
    ctl_nx = ctl_we ? (ctl_wdata & CTL_MASK) : ctl_q;
    if (addr_done) ctl_nx[0] = 1'b0;
    if (addr_nak || data_nak || go_fin) ctl_nx[1] = 1'b0;
    if (addr_nak || data_nak || go_fin || expire) ctl_nx[10] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q        <= '0;
      cnt_prog     <= '0;
      cnt_cur      <= '0;
      access_ready <= 1'b0;
      no_ack       <= 1'b0;
    end else begin
      ctl_q <= ctl_nx;
      if (cnt_we) cnt_prog <= cnt_wdata;
      if (addr_done || fin_done)  cnt_cur <= cnt_prog;
      else if (xfer_done && !rpt) cnt_cur <= cnt_cur - 1'b1;
      if (expire)        access_ready <= 1'b1;
      else if (ardy_clr) access_ready <= 1'b0;
      if (addr_nak || data_nak) no_ack <= 1'b1;
      else if (nack_clr)        no_ack <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      lvl <= '0;
    end else begin
      if (do_push) begin
        mem[wp] <= push_byte;
        wp      <= wp + 1'b1;
      end
      if (do_pop) rp <= rp + 1'b1;
      if (do_push && !do_pop)      lvl <= lvl + 1'b1;
      else if (do_pop && !do_push) lvl <= lvl - 1'b1;
    end
  end

  assign buf_rdata = mem[rp];
  assign buf_level = lvl;
  assign cnt_q     = cnt_cur;
  assign tx_ready  = trx && ((state == S_RUN) || (state == S_XFER)) && (rpt || !cnt_zero);
  assign rx_ready  = !trx && !empty;

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid && !eng_done |=> eng_valid && $stable(eng_op) && $stable(eng_data));
  assert_send_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid && eng_op == OP_SEND |-> ctl_q[9]);
  assert_level_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_level <= FULL_LVL);
  assert_ardy_drops_master_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(access_ready) |-> !ctl_q[10]);
  assert_nak_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid && eng_op == OP_SEND && eng_done && !eng_ack |=> no_ack && eng_valid && eng_op == OP_END);
  assert_repeat_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid && eng_done && eng_op != OP_START && eng_op != OP_END && ctl_q[2] |=> $stable(cnt_q));
endmodule

// File: tb/byte_xfer_seq_tb_top.sv
module byte_xfer_seq_tb_top;
  localparam logic [15:0] EN = 16'h8000, MST = 16'h0400, TRX = 16'h0200,
                          RPT = 16'h0004, STP = 16'h0002, STT = 16'h0001;
  localparam logic [6:0] SLA = 7'h5A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 0, cnt_we = 0, buf_push = 0, buf_pop = 0;
  logic [15:0] ctl_wdata = '0, cnt_wdata = '0;
  logic [7:0] buf_wdata = '0, eng_rdata = '0;
  logic eng_done = 0, eng_ack = 1, ardy_clr = 0, nack_clr = 0;
  logic [15:0] ctl_q, cnt_q;
  logic [7:0] buf_rdata, eng_data;
  logic [2:0] buf_level;
  logic eng_valid, access_ready, no_ack, tx_ready, rx_ready;
  logic [1:0] eng_op;

  byte_xfer_seq #(.CNT_W(16), .DEPTH(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_q(cnt_q), .slave_addr(SLA),
    .buf_push(buf_push), .buf_wdata(buf_wdata), .buf_pop(buf_pop), .buf_rdata(buf_rdata),
    .buf_level(buf_level), .eng_valid(eng_valid), .eng_op(eng_op), .eng_data(eng_data),
    .eng_done(eng_done), .eng_ack(eng_ack), .eng_rdata(eng_rdata),
    .access_ready(access_ready), .no_ack(no_ack), .tx_ready(tx_ready), .rx_ready(rx_ready),
    .ardy_clr(ardy_clr), .nack_clr(nack_clr));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int op_log[64];
  logic [7:0] dat_log[64];
  int n_log = 0, nack_idx = -1, rx_ctr = 0, popped = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R11 watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // engine model: answers each request one cycle after it appears
  always @(negedge clk) begin
    if (eng_done) eng_done = 1'b0;
    else if (eng_valid) begin
      if (n_log < 64) begin
        op_log[n_log] = int'(eng_op);
        dat_log[n_log] = eng_data;
      end
      eng_ack = (n_log != nack_idx);
      eng_rdata = 8'hA0 + rx_ctr[7:0];
      if (eng_op == 2'd2) rx_ctr++;
      n_log++;
      eng_done = 1'b1;
    end
  end

  task automatic wr_ctl(logic [15:0] v);
    @(negedge clk); ctl_we = 1; ctl_wdata = v;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic wr_cnt(logic [15:0] v);
    @(negedge clk); cnt_we = 1; cnt_wdata = v;
    @(negedge clk); cnt_we = 0;
  endtask

  task automatic clr_all();
    @(negedge clk); ardy_clr = 1; nack_clr = 1;
    @(negedge clk); ardy_clr = 0; nack_clr = 0;
  endtask

  task automatic fresh();
    n_log = 0; rx_ctr = 0; popped = 0; nack_idx = -1;
  endtask

  // pop_mode: 0 none, 1 pop and check receive data, 2 pop without check
  task automatic drive(int push_total, int pop_mode, int max_cyc);
    int pushed = 0;
    int quiet = 0;
    for (int i = 0; i < max_cyc && quiet < 4; i++) begin
      @(negedge clk); buf_push = 0; buf_pop = 0;
      if (pushed < push_total && buf_level < 4) begin
        buf_push = 1; buf_wdata = 8'h10 + pushed[7:0]; pushed++;
      end
      if (pop_mode != 0 && buf_level != 0) begin
        if (pop_mode == 1)
          chk(buf_rdata == 8'hA0 + popped[7:0], "R6 rx byte order", buf_rdata, 8'hA0 + popped[7:0]);
        popped++; buf_pop = 1;
      end
      if (!eng_valid && !ctl_q[10] && (pop_mode == 0 || buf_level == 0)) quiet++;
      else quiet = 0;
    end
    @(negedge clk); buf_push = 0; buf_pop = 0;
  endtask

  task automatic chk_log(string tag, int nb, int bop, logic dir, bit fin);
    chk(n_log == 1 + nb + int'(fin), $sformatf("%s op count", tag), n_log, 1 + nb + int'(fin));
    chk(op_log[0] == 0 && dat_log[0] == {SLA, dir}, $sformatf("R3 %s addr op", tag),
        dat_log[0], {SLA, dir});
    for (int k = 0; k < nb; k++)
      chk(op_log[1+k] == bop && (bop != 1 || dat_log[1+k] == 8'h10 + k[7:0]),
          $sformatf("%s byte %0d", tag, k), {op_log[1+k][7:0], dat_log[1+k]},
          {bop[7:0], (bop == 1) ? 8'h10 + k[7:0] : dat_log[1+k]});
    if (fin) chk(op_log[1+nb] == 3, $sformatf("R8 %s end op", tag), op_log[1+nb], 3);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ctl_q == 0 && cnt_q == 0 && buf_level == 0, "R1 reset regs", {ctl_q, cnt_q}, 0);
    chk({eng_valid, access_ready, no_ack, tx_ready, rx_ready} == 0, "R1 reset outputs",
        {eng_valid, access_ready, no_ack, tx_ready, rx_ready}, 0);

    wr_ctl(16'h7FFF);
    chk(ctl_q == 16'h4F87, "R2 mask", ctl_q, 16'h4F87);
    wr_ctl(16'hFF7E);
    repeat (5) @(negedge clk);
    chk(ctl_q == 16'hCF06 && !eng_valid && n_log == 0, "R2 no start without start bit",
        ctl_q, 16'hCF06);
    wr_ctl(16'h0000);

    // counted sweep: direction x count x stop
    for (int d = 0; d < 2; d++)
      for (int n = 0; n <= 6; n++)
        for (int s = 0; s < 2; s++) begin
          string tag;
          tag = $sformatf("%s n=%0d s=%0d", d ? "R6 rx" : "R5 tx", n, s);
          fresh(); clr_all(); wr_cnt(16'(n));
          wr_ctl(EN | MST | STT | (d ? 16'h0 : TRX) | (s ? STP : 16'h0));
          if (d == 0 && n == 3 && s == 0) begin
            repeat (4) @(negedge clk);
            chk(tx_ready && !eng_valid && n_log == 1, "R5 tx waits for data", tx_ready, 1);
            chk(cnt_q == 3 && ctl_q[0] == 0, "R3 count loaded start cleared", cnt_q, 3);
          end
          drive(d ? 0 : n, d ? 1 : 0, 300);
          chk_log(tag, n, d ? 2 : 1, d[0], s[0]);
          if (d == 1) chk(popped == n, $sformatf("R6 popped %s", tag), popped, n);
          chk(cnt_q == (s ? n : 0), $sformatf("%s R7 R8 count readback", tag), cnt_q, s ? n : 0);
          chk(access_ready && !no_ack, $sformatf("%s R7 R8 ardy", tag), {access_ready, no_ack}, 2);
          chk(ctl_q == (EN | (d ? 16'h0 : TRX)), $sformatf("%s R7 R8 ctl bits", tag), ctl_q,
              EN | (d ? 16'h0 : TRX));
          chk(!tx_ready && !rx_ready && buf_level == 0, $sformatf("%s idle ready flags", tag),
              {tx_ready, rx_ready}, 0);
        end

    // sticky flags and their separate clears
    repeat (10) @(negedge clk);
    chk(access_ready, "R12 ardy sticky", access_ready, 1);
    @(negedge clk); ardy_clr = 1; @(negedge clk); ardy_clr = 0;
    chk(!access_ready, "R12 ardy cleared", access_ready, 0);

    // receive stall on full buffer
    fresh(); clr_all(); wr_cnt(16'd6);
    wr_ctl(EN | MST | STT | STP);
    repeat (30) @(negedge clk);
    chk(buf_level == 4 && n_log == 5 && !eng_valid, "R6 stall when full", {buf_level, n_log[7:0]}, 16'h0405);
    chk(rx_ready && cnt_q == 2, "R6 rx_ready and count", {rx_ready, cnt_q}, {1'b1, 16'd2});
    drive(0, 1, 300);
    chk_log("R6 stall", 6, 2, 1'b1, 1'b1);

    // data refusal
    fresh(); clr_all(); wr_cnt(16'd5); nack_idx = 3;
    wr_ctl(EN | MST | STT | TRX | STP);
    drive(5, 0, 300);
    chk(n_log == 5 && op_log[3] == 1 && op_log[4] == 3, "R9 ops after refusal", n_log, 5);
    chk(dat_log[3] == 8'h12, "R9 last sent byte", dat_log[3], 8'h12);
    chk(no_ack && !access_ready, "R9 no_ack set", {no_ack, access_ready}, 2);
    chk(ctl_q == (EN | TRX) && cnt_q == 5, "R9 stop master cleared, reload", ctl_q, EN | TRX);
    @(negedge clk); nack_clr = 1; @(negedge clk); nack_clr = 0;
    chk(!no_ack, "R12 nack cleared", no_ack, 0);
    wr_ctl(EN); drive(0, 2, 40);
    chk(buf_level == 0, "R9 leftover drained", buf_level, 0);

    // address refusal
    fresh(); clr_all(); wr_cnt(16'd3); nack_idx = 0;
    wr_ctl(EN | MST | STT | STP);
    drive(0, 1, 100);
    chk(n_log == 2 && op_log[1] == 3, "R4 end after addr refusal", n_log, 2);
    chk(no_ack && !access_ready && ctl_q == EN, "R4 flags and ctl", ctl_q, EN);

    // repeat transmit
    fresh(); clr_all(); wr_cnt(16'd9);
    wr_ctl(EN | MST | RPT | TRX | STT);
    drive(6, 0, 40);
    chk(n_log == 7, "R10 rpt tx sends all", n_log, 7);
    for (int k = 0; k < 6; k++)
      chk(op_log[1+k] == 1 && dat_log[1+k] == 8'h10 + k[7:0], "R10 rpt tx byte", dat_log[1+k], 8'h10 + k[7:0]);
    chk(cnt_q == 9 && ctl_q[10] && tx_ready, "R10 rpt count held", cnt_q, 9);
    wr_ctl(EN | MST | RPT | TRX | STP);
    drive(0, 0, 40);
    chk(n_log == 8 && op_log[7] == 3, "R10 rpt stop ends", n_log, 8);
    chk(!access_ready && ctl_q == (EN | RPT | TRX), "R10 rpt stop no ardy", ctl_q, EN | RPT | TRX);

    // repeat receive
    fresh(); clr_all(); wr_cnt(16'd9);
    wr_ctl(EN | MST | RPT | STT);
    repeat (30) @(negedge clk);
    chk(n_log == 5 && buf_level == 4 && cnt_q == 9, "R10 rpt rx fills to 4", n_log, 5);
    wr_ctl(EN | MST | RPT | STP);
    drive(0, 1, 60);
    chk(n_log == 6 && op_log[5] == 3 && popped == 4, "R10 rpt rx stop", n_log, 6);
    chk(!access_ready, "R10 rpt rx no ardy", access_ready, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule